// File: doc/BRIEF.md
# Display scan-line address generator

This block computes the memory fetch addresses that a raster display controller issues for two buffers held in a graphics memory aperture of up to 4 MB: the uncompressed frame buffer and the compressed display buffer. Software writes each buffer's start offset, its per-line step in DWORDs and its number of active DWORDs per line through a small register port. A timing generator supplies a frame-start strobe and a line-start strobe. At each strobe the block sets the line pointer of each buffer, then streams one byte address per DWORD of the line on a valid/ready request port.

The upper bits of the frame-buffer start offset are shadowed. A write to them waits for the next frame-start strobe. The low four bits are a sub-word pixel offset, and they reach the output at once. Every offset is a 22-bit value that wraps inside the aperture before the graphics base address is added. Compressed fetches are blocked while the frame-buffer start offset in force is nonzero.

Top module: `scanline_addr_gen`

## Requirements
- R1: After reset, both request valids are low, the pixel offset output is 0 and every register reads back as 0.
- R2: A write to frame-buffer start offset bits [21:4] (select 0) does not change any frame-buffer address until the next frame-start strobe, which loads the new value into the line pointer.
- R3: Frame-buffer start offset bits [3:0] appear on the pixel offset output in the cycle after the write, with no strobe needed.
- R4: The compressed start offset (select 1) keeps bits [3:0] at zero, both in its readback and in the addresses it produces.
- R5: A frame-start strobe loads each line pointer from its start offset. Each later line-start strobe adds 4 x delta bytes to the previous line's start. Select 2 holds the compressed delta in bits [21:12] and the frame-buffer delta in bits [9:0].
- R6: Line pointer and in-line offset sums wrap modulo 2^22 bytes, and the graphics base address is added after the wrap.
- R7: The request address is base + line pointer + 4 x (DWORDs already accepted). It advances by 4 only when valid and ready are both high, and it holds while ready is low.
- R8: Select 3 holds the active DWORD count per line: compressed in bits [21:12], frame buffer in bits [9:0]. After that many accepted requests, valid stays low until the next strobe. A count of 0 produces no request.
- R9: While the frame-buffer start offset in force is nonzero, the compressed valid is low. The offset in force is the latched upper bits together with the current pixel bits.
- R10: Readback bits [31:22] of every register are 0. Unused bits [11:10] of selects 2 and 3 read as 0.
- R11: When the frame-start and line-start strobes arrive in the same cycle, the frame start wins and the pointer loads without a delta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select for the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Register select for the readback |
| cfg_rd_data | output | 32 | Readback data, combinational |
| gfx_base | input | ADDR_W | Graphics aperture base byte address |
| frame_start | input | 1 | One-cycle frame-start strobe |
| line_start | input | 1 | One-cycle line-start strobe |
| fb_req_valid | output | 1 | Frame-buffer fetch request valid |
| fb_req_ready | input | 1 | Frame-buffer fetch request accepted |
| fb_req_addr | output | ADDR_W | Frame-buffer fetch byte address |
| fb_pix_ofs | output | 4 | Frame-buffer sub-word pixel offset |
| cb_req_valid | output | 1 | Compressed-buffer fetch request valid |
| cb_req_ready | input | 1 | Compressed-buffer fetch request accepted |
| cb_req_addr | output | ADDR_W | Compressed-buffer fetch byte address |

## Verification
Several properties are checked on every cycle:
- A stalled frame-buffer request keeps its offset, and each accepted request moves the offset by exactly 4 bytes, wrapping inside the aperture.
- The latched upper start bits change only on a frame start.
- Compressed requests never appear while the frame-buffer start offset in force is nonzero.
- Readback keeps its reserved and alignment bits at zero.

Other behaviours need the bench's scenarios:
- Absolute addresses after a chain of line deltas, including the 4 MB wrap.
- The one-frame delay of a start-offset write.
- The immediate pixel-offset update.
- Line-length cut-off, including a zero-length line.
- Strobe priority.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

  typedef enum logic [1:0] {
    SEL_FB_START = 2'd0,
    SEL_CB_START = 2'd1,
    SEL_DELTA    = 2'd2,
    SEL_LENGTH   = 2'd3
  } reg_sel_e;

  localparam int REG_W        = 32;
  localparam int APERTURE_W   = 22;
  localparam int FIELD_W      = 10;
  localparam int HI_FIELD_LSB = 12;
  localparam int GAP_W        = HI_FIELD_LSB - FIELD_W;
  localparam int PIX_W        = 4;

endpackage

// File: rtl/sla_regs.sv
module sla_regs
  import scanline_pkg::*;
#(
  parameter int OFS_W = APERTURE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [1:0]         rd_sel,
  output logic [REG_W-1:0]   rd_data,
  input  logic               frame_start,
  output logic [OFS_W-1:0]   fb_load_ofs,
  output logic [OFS_W-1:0]   cb_load_ofs,
  output logic [OFS_W-1:0]   fb_start_eff,
  output logic [OFS_W-PIX_W-1:0] fb_hi_live,
  output logic [PIX_W-1:0]   fb_pix,
  output logic [FIELD_W-1:0] fb_delta,
  output logic [FIELD_W-1:0] cb_delta,
  output logic [FIELD_W-1:0] fb_len,
  output logic [FIELD_W-1:0] cb_len
);
  localparam int HI_W = OFS_W - PIX_W;

  logic [HI_W-1:0]    fb_hi_pend_q;
  logic [HI_W-1:0]    fb_hi_act_q;
  logic [HI_W-1:0]    cb_hi_q;
  logic [PIX_W-1:0]   fb_pix_q;
  logic [FIELD_W-1:0] fb_delta_q;
  logic [FIELD_W-1:0] cb_delta_q;
  logic [FIELD_W-1:0] fb_len_q;
  logic [FIELD_W-1:0] cb_len_q;
  logic               unused_rsvd;

  assign unused_rsvd = ^wr_data[REG_W-1:OFS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_hi_pend_q <= '0;
      fb_hi_act_q  <= '0;
      cb_hi_q      <= '0;
      fb_pix_q     <= '0;
      fb_delta_q   <= '0;
      cb_delta_q   <= '0;
      fb_len_q     <= '0;
      cb_len_q     <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_FB_START: begin
            fb_hi_pend_q <= wr_data[OFS_W-1:PIX_W];
            fb_pix_q     <= wr_data[PIX_W-1:0];
          end
          SEL_CB_START: cb_hi_q <= wr_data[OFS_W-1:PIX_W];
          SEL_DELTA: begin
            fb_delta_q <= wr_data[FIELD_W-1:0];
            cb_delta_q <= wr_data[HI_FIELD_LSB +: FIELD_W];
          end
          default: begin
            fb_len_q <= wr_data[FIELD_W-1:0];
            cb_len_q <= wr_data[HI_FIELD_LSB +: FIELD_W];
          end
        endcase
      end
      // shadowed upper bits come into force only at a frame boundary
      if (frame_start) fb_hi_act_q <= fb_hi_pend_q;
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_FB_START: rd_data = REG_W'({fb_hi_pend_q, fb_pix_q});
      SEL_CB_START: rd_data = REG_W'({cb_hi_q, {PIX_W{1'b0}}});
      SEL_DELTA:    rd_data = REG_W'({cb_delta_q, {GAP_W{1'b0}}, fb_delta_q});
      default:      rd_data = REG_W'({cb_len_q, {GAP_W{1'b0}}, fb_len_q});
    endcase
  end

  assign fb_load_ofs  = {fb_hi_pend_q, {PIX_W{1'b0}}};
  assign cb_load_ofs  = {cb_hi_q, {PIX_W{1'b0}}};
  assign fb_start_eff = {fb_hi_act_q, fb_pix_q};
  assign fb_hi_live   = fb_hi_act_q;
  assign fb_pix       = fb_pix_q;
  assign fb_delta     = fb_delta_q;
  assign cb_delta     = cb_delta_q;
  assign fb_len       = fb_len_q;
  assign cb_len       = cb_len_q;

endmodule

// File: rtl/sla_line_walker.sv
module sla_line_walker #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 22,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              enable,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic [CNT_W-1:0]  delta,
  input  logic [CNT_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [OFS_W-1:0]  fetch_ofs,
  output logic              fire
);
  logic [OFS_W-1:0] line_q;
  logic [CNT_W-1:0] cnt_q;
  logic             live_q;

  function automatic logic [OFS_W-1:0] next_line(input logic [OFS_W-1:0] cur,
                                                 input logic [CNT_W-1:0] dwords);
    return cur + OFS_W'({dwords, 2'b00});
  endfunction

  function automatic logic [OFS_W-1:0] dword_ofs(input logic [OFS_W-1:0] line,
                                                 input logic [CNT_W-1:0] cnt);
    return line + OFS_W'({cnt, 2'b00});
  endfunction

  function automatic logic [ADDR_W-1:0] bus_addr(input logic [ADDR_W-1:0] b,
                                                 input logic [OFS_W-1:0] ofs);
    return b + ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (frame_start) begin
      line_q <= load_ofs;
      cnt_q  <= '0;
      live_q <= 1'b1;
    end else if (line_start) begin
      line_q <= next_line(line_q, delta);
      cnt_q  <= '0;
    end else if (fire) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign valid     = live_q && enable && (cnt_q < len);
  assign fire      = valid && ready;
  assign fetch_ofs = dword_ofs(line_q, cnt_q);
  assign addr      = bus_addr(base, fetch_ofs);

endmodule

// File: rtl/scanline_addr_gen.sv
module scanline_addr_gen
  import scanline_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = APERTURE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [1:0]        cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] gfx_base,
  input  logic              frame_start,
  input  logic              line_start,
  output logic              fb_req_valid,
  input  logic              fb_req_ready,
  output logic [ADDR_W-1:0] fb_req_addr,
  output logic [PIX_W-1:0]  fb_pix_ofs,
  output logic              cb_req_valid,
  input  logic              cb_req_ready,
  output logic [ADDR_W-1:0] cb_req_addr
);
  logic [OFS_W-1:0]       fb_load_ofs;
  logic [OFS_W-1:0]       cb_load_ofs;
  logic [OFS_W-1:0]       fb_start_eff;
  logic [OFS_W-PIX_W-1:0] fb_hi_live;
  logic [FIELD_W-1:0]     fb_delta;
  logic [FIELD_W-1:0]     cb_delta;
  logic [FIELD_W-1:0]     fb_len;
  logic [FIELD_W-1:0]     cb_len;
  logic                   cb_allowed;
  logic [OFS_W-1:0]       fb_fetch_ofs;
  logic [OFS_W-1:0]       cb_fetch_ofs;
  logic                   fb_fire;
  logic                   cb_fire;

  sla_regs #(.OFS_W(OFS_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr_en),
    .wr_sel       (cfg_wr_sel),
    .wr_data      (cfg_wr_data),
    .rd_sel       (cfg_rd_sel),
    .rd_data      (cfg_rd_data),
    .frame_start  (frame_start),
    .fb_load_ofs  (fb_load_ofs),
    .cb_load_ofs  (cb_load_ofs),
    .fb_start_eff (fb_start_eff),
    .fb_hi_live   (fb_hi_live),
    .fb_pix       (fb_pix_ofs),
    .fb_delta     (fb_delta),
    .cb_delta     (cb_delta),
    .fb_len       (fb_len),
    .cb_len       (cb_len)
  );

  // compressed fetch is only legal while the frame buffer starts at offset 0
  assign cb_allowed = (fb_start_eff == '0);

  sla_line_walker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(FIELD_W)) fb_walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .enable      (1'b1),
    .load_ofs    (fb_load_ofs),
    .delta       (fb_delta),
    .len         (fb_len),
    .base        (gfx_base),
    .ready       (fb_req_ready),
    .valid       (fb_req_valid),
    .addr        (fb_req_addr),
    .fetch_ofs   (fb_fetch_ofs),
    .fire        (fb_fire)
  );

  sla_line_walker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(FIELD_W)) cb_walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .enable      (cb_allowed),
    .load_ofs    (cb_load_ofs),
    .delta       (cb_delta),
    .len         (cb_len),
    .base        (gfx_base),
    .ready       (cb_req_ready),
    .valid       (cb_req_valid),
    .addr        (cb_req_addr),
    .fetch_ofs   (cb_fetch_ofs),
    .fire        (cb_fire)
  );

endmodule

// File: rtl/sla_checker.sv
module sla_checker #(
  parameter int OFS_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             line_start,
  input logic             cfg_wr_en,
  input logic [1:0]       cfg_rd_sel,
  input logic [31:0]      cfg_rd_data,
  input logic             fb_req_valid,
  input logic             fb_req_ready,
  input logic [OFS_W-1:0] fb_fetch_ofs,
  input logic             cb_req_valid,
  input logic [OFS_W-1:0] fb_start_eff,
  input logic [OFS_W-5:0] fb_hi_live
);

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[31:OFS_W] == '0);

  assert_cb_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_sel == 2'd1) |-> (cfg_rd_data[3:0] == 4'd0));

  assert_cb_suppress_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_start_eff != '0) |-> !cb_req_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req_valid && !fb_req_ready && !frame_start && !line_start && !cfg_wr_en)
      |=> (fb_req_valid && $stable(fb_fetch_ofs)));

  assert_step_four_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req_valid && fb_req_ready && !frame_start && !line_start)
      |=> (fb_fetch_ofs == OFS_W'($past(fb_fetch_ofs) + 4)));

  assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fb_hi_live));

endmodule

bind scanline_addr_gen sla_checker #(.OFS_W(OFS_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .line_start   (line_start),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_rd_sel   (cfg_rd_sel),
  .cfg_rd_data  (cfg_rd_data),
  .fb_req_valid (fb_req_valid),
  .fb_req_ready (fb_req_ready),
  .fb_fetch_ofs (fb_fetch_ofs),
  .cb_req_valid (cb_req_valid),
  .fb_start_eff (fb_start_eff),
  .fb_hi_live   (fb_hi_live)
);

// File: tb/scanline_addr_gen_tb.sv
`timescale 1ns/1ps
module scanline_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  cfg_rd_sel = '0;
  logic [31:0] cfg_rd_data;
  logic [31:0] gfx_base = '0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        fb_req_valid;
  logic        fb_req_ready = 1'b0;
  logic [31:0] fb_req_addr;
  logic [3:0]  fb_pix_ofs;
  logic        cb_req_valid;
  logic        cb_req_ready = 1'b0;
  logic [31:0] cb_req_addr;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  scanline_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .gfx_base(gfx_base), .frame_start(frame_start), .line_start(line_start),
    .fb_req_valid(fb_req_valid), .fb_req_ready(fb_req_ready),
    .fb_req_addr(fb_req_addr), .fb_pix_ofs(fb_pix_ofs),
    .cb_req_valid(cb_req_valid), .cb_req_ready(cb_req_ready),
    .cb_req_addr(cb_req_addr)
  );

  // {base, start, fb delta, line strobes after frame, expected address}
  localparam logic [99:0] VEC_TAB [4] = '{
    {32'h1000_0000, 22'h000100, 10'h050, 4'd0, 32'h1000_0100},
    {32'h1000_0000, 22'h000100, 10'h050, 4'd3, 32'h1000_04C0},
    {32'h2000_0000, 22'h3FFF00, 10'h3FF, 4'd1, 32'h2000_0EFC},
    {32'h0040_0000, 22'h012345, 10'h010, 4'd2, 32'h0041_23C0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    cfg_rd_sel = sel;
    #0.5;
    data = cfg_rd_data;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fb valid", 32'(fb_req_valid), 32'd0);
    chk("R1 cb valid", 32'(cb_req_valid), 32'd0);
    chk("R1 pix", 32'(fb_pix_ofs), 32'd0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), rv);
      chk("R1 readback", rv, 32'd0);
    end

    // table walk: frame reload, delta chain, wrap, pixel offset
    wr(2'd3, 32'h0000_4004);
    for (int i = 0; i < 4; i++) begin
      gfx_base = VEC_TAB[i][99:68];
      wr(2'd0, 32'(VEC_TAB[i][67:46]));
      wr(2'd2, 32'(VEC_TAB[i][45:36]));
      pulse_frame();
      for (int k = 0; k < int'(VEC_TAB[i][35:32]); k++) pulse_line();
      chk("R5 table valid", 32'(fb_req_valid), 32'd1);
      chk("R5/R6 table addr", fb_req_addr, VEC_TAB[i][31:0]);
      chk("R3 table pix", 32'(fb_pix_ofs), 32'(VEC_TAB[i][49:46]));
    end

    // R2 shadowed upper bits
    gfx_base = 32'h0;
    wr(2'd0, 32'h1000);
    pulse_frame();
    chk("R2 first frame", fb_req_addr, 32'h1000);
    wr(2'd0, 32'h2000);
    wr(2'd2, 32'h20);
    pulse_line();
    chk("R2 old start kept", fb_req_addr, 32'h1080);
    pulse_frame();
    chk("R2 new start at frame", fb_req_addr, 32'h2000);

    // R3 immediate pixel offset
    wr(2'd0, 32'h2009);
    chk("R3 pix now", 32'(fb_pix_ofs), 32'h9);
    chk("R2 pointer untouched", fb_req_addr, 32'h2000);

    // R7 stall holds
    repeat (3) @(negedge clk);
    chk("R7 stall valid", 32'(fb_req_valid), 32'd1);
    chk("R7 stall addr", fb_req_addr, 32'h2000);

    // R7/R8 stream of three DWORDs
    wr(2'd3, 32'h0000_4003);
    pulse_frame();
    for (int k = 0; k < 3; k++) begin
      chk("R7 stream valid", 32'(fb_req_valid), 32'd1);
      chk("R7 stream addr", fb_req_addr, 32'h2000 + 32'(4 * k));
      fb_req_ready = 1'b1;
      @(negedge clk);
    end
    chk("R8 stop after len", 32'(fb_req_valid), 32'd0);
    @(negedge clk);
    chk("R8 still stopped", 32'(fb_req_valid), 32'd0);
    fb_req_ready = 1'b0;

    // R8 zero length
    wr(2'd3, 32'h0000_4000);
    pulse_frame();
    chk("R8 zero len", 32'(fb_req_valid), 32'd0);

    // R4 / R9 compressed buffer
    gfx_base = 32'h3000_0000;
    wr(2'd0, 32'h0);
    pulse_frame();
    wr(2'd1, 32'h0001_2347);
    rd(2'd1, rv);
    chk("R4 cb readback", rv, 32'h0001_2340);
    pulse_frame();
    chk("R9 cb enabled", 32'(cb_req_valid), 32'd1);
    chk("R4 cb addr", cb_req_addr, 32'h3001_2340);
    wr(2'd0, 32'h4);
    chk("R9 pix blocks cb", 32'(cb_req_valid), 32'd0);
    wr(2'd0, 32'h0);
    chk("R9 cb back", 32'(cb_req_valid), 32'd1);
    wr(2'd0, 32'h100);
    chk("R9 pending not in force", 32'(cb_req_valid), 32'd1);
    pulse_frame();
    chk("R9 in force blocks cb", 32'(cb_req_valid), 32'd0);

    // R5 compressed line step
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h100);
    wr(2'd2, 32'h0002_0000);
    pulse_frame();
    pulse_line();
    chk("R5 cb step", cb_req_addr, 32'h3000_0180);

    // R10 reserved bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, rv);
    chk("R10 delta readback", rv, 32'h003F_F3FF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rv);
    chk("R10 fb start readback", rv, 32'h003F_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, rv);
    chk("R10 cb start readback", rv, 32'h003F_FFF0);

    // R11 frame start wins over line start
    gfx_base = 32'h0;
    wr(2'd0, 32'h800);
    wr(2'd2, 32'h10);
    wr(2'd3, 32'h0000_4004);
    @(negedge clk); frame_start = 1'b1; line_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
    chk("R11 priority", fb_req_addr, 32'h800);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule